// File: doc/BRIEF.md
# Parallel Command Bus Panel Host Port

This block lets software run single transfers to a panel module over an 8080-style parallel command bus. It sends an index (command) word, a data word, or reads one data word back. Software loads a command word into the write-word register and then writes the write-trigger register. For a read, it writes a setup word to the read-word register and then writes the read-trigger register. While the transfer runs, software polls the busy bit in the status register. When a read finishes, the 16-bit result is in the read-word register.

The panel side has two active-low chip selects (main and secondary), a register-select line, active-low write and read strobes, and a 16-bit data bus. The data bus is split into an output, an output enable and an input. Every transfer passes through three phases: setup, strobe and hold. Each phase lasts a programmable number of clock cycles.

The sequencer has four named states. PH_IDLE waits for a start and goes to PH_SETUP when an accepted trigger arrives. PH_SETUP holds chip select for the setup width and then goes to PH_STROBE. PH_STROBE pulls the write or read strobe low for the active width. For a read it captures the bus on its last cycle. It then goes to PH_HOLD. PH_HOLD keeps chip select and data for the hold width and then returns to PH_IDLE.

Top module: `lcdp_host_port`

Host register offsets (word index on `host_addr`) are 0 write-word, 1 write-trigger, 2 read-word, 3 read-trigger, 4 status, and 5 timing. The timing register holds the setup width in bits 7:0, the active width in bits 15:8 and the hold width in bits 23:16. Its reset value gives setup 1, active 2 and hold 1.

## Requirements
- R1: After reset, both chip selects, the write strobe and the read strobe are high, the data output enable is low, status reads 0, and timing reads 0x00010201.
- R2: A write-trigger word with bit 0 set starts a write. The bus carries write-word bits 15:0 with the output enable high for the whole transfer. Register-select follows write-word bit 24: 0 gives an index write, 1 gives a data write. Bit 28 marks the word as a write word. The data stays stable while the strobe is low.
- R3: Trigger bit 1 selects the chip select. 0 drives the main panel select (`pnl_cs_n[0]`) and 1 drives the secondary select (`pnl_cs_n[1]`). Never more than one select is low.
- R4: Status bit 1 reads 1 on every cycle of a transfer and 0 otherwise. A chip select is low exactly while busy. A transfer lasts setup+active+hold cycles.
- R5: Chip select is low for exactly the setup width before the strobe falls. The strobe stays low for exactly the active width. A width field of 0 counts as 1.
- R6: A read-trigger word with bit 0 set starts a read. The output enable stays low throughout, the read strobe is low for the active width, and register-select follows read-word bit 24 as last written.
- R7: The read bus is sampled at the rising edge of the read strobe. The read-word register then reads that value in bits 15:0, with bits 31:16 zero.
- R8: A trigger with bit 0 set that arrives while busy is ignored and does not change the running transfer. It sets status bit 2, which stays set until software writes status with bit 2 set.
- R9: A trigger word with bit 0 clear starts nothing.
- R10: The write and read strobes are never low together, and a strobe is low only while a chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | 3 | Register word index |
| host_wr | input | 1 | Register write enable |
| host_wdata | input | 32 | Register write data |
| host_rdata | output | 32 | Register read data (combinational on host_addr) |
| pnl_cs_n | output | 2 | Chip selects, bit 0 main, bit 1 secondary |
| pnl_rs | output | 1 | Register-select, 0 index, 1 data |
| pnl_wr_n | output | 1 | Write strobe |
| pnl_rd_n | output | 1 | Read strobe |
| pnl_d_out | output | 16 | Bus data driven to the panel |
| pnl_d_oe | output | 1 | Bus output enable |
| pnl_d_in | input | 16 | Bus data from the panel |

## Verification
Random transfers mix writes and reads, both register-select values, both panels, data words and phase widths from 0 to 5. This separates a mix-up of width fields or of select lines from a correct phase count. The read bus value changes right after the strobe rises, so a capture one cycle late returns the wrong word. Directed cases cover zero widths, one wide transfer, a trigger with bit 0 clear, and a trigger that lands mid-transfer. Those cases show that an ignored trigger neither restarts nor alters the bus, and that the error flag survives until it is cleared.

// File: rtl/lcdp_pkg.sv
package lcdp_pkg;
    localparam int DATA_W     = 16;
    localparam int REG_W      = 32;
    localparam int ADDR_W     = 3;
    localparam int NUM_PANELS = 2;

    localparam logic [ADDR_W-1:0] A_WWORD = 3'd0;
    localparam logic [ADDR_W-1:0] A_WTRIG = 3'd1;
    localparam logic [ADDR_W-1:0] A_RWORD = 3'd2;
    localparam logic [ADDR_W-1:0] A_RTRIG = 3'd3;
    localparam logic [ADDR_W-1:0] A_STAT  = 3'd4;
    localparam logic [ADDR_W-1:0] A_TIME  = 3'd5;

    localparam int B_RS     = 24;
    localparam int B_GO     = 0;
    localparam int B_PANEL  = 1;
    localparam int B_BUSY   = 1;
    localparam int B_ERR    = 2;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD
    } phase_t;

    typedef struct packed {
        logic              is_read;
        logic              panel;
        logic              rs;
        logic [DATA_W-1:0] data;
    } xfer_t;
endpackage

// File: rtl/lcdp_regs.sv
module lcdp_regs
    import lcdp_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic [REG_W-1:0]  host_wdata,
    output logic [REG_W-1:0]  host_rdata,
    input  logic              busy,
    input  logic [DATA_W-1:0] rd_result,
    output logic              start,
    output xfer_t             start_xfer,
    output logic [CNT_W-1:0]  t_setup,
    output logic [CNT_W-1:0]  t_active,
    output logic [CNT_W-1:0]  t_hold,
    output logic              err_flag,
    output logic              trig_any
);
    localparam int TIME_USED = 3 * CNT_W;

    logic [REG_W-1:0] wword_q;
    logic [REG_W-1:0] rword_q;
    logic             err_q;
    logic             trig_w;
    logic             trig_r;

    assign trig_w   = host_wr && (host_addr == A_WTRIG) && host_wdata[B_GO];
    assign trig_r   = host_wr && (host_addr == A_RTRIG) && host_wdata[B_GO];
    assign trig_any = trig_w || trig_r;
    assign start    = trig_any && !busy;
    assign err_flag = err_q;

    always_comb begin
        start_xfer.is_read = trig_r;
        start_xfer.panel   = host_wdata[B_PANEL];
        start_xfer.rs      = trig_r ? rword_q[B_RS] : wword_q[B_RS];
        start_xfer.data    = wword_q[DATA_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wword_q  <= '0;
            rword_q  <= '0;
            t_setup  <= CNT_W'(1);
            t_active <= CNT_W'(2);
            t_hold   <= CNT_W'(1);
        end else if (host_wr) begin
            unique case (host_addr)
                A_WWORD: wword_q <= host_wdata;
                A_RWORD: rword_q <= host_wdata;
                A_TIME: begin
                    t_setup  <= host_wdata[CNT_W-1:0];
                    t_active <= host_wdata[2*CNT_W-1:CNT_W];
                    t_hold   <= host_wdata[3*CNT_W-1:2*CNT_W];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (trig_any && busy) begin
            err_q <= 1'b1;
        end else if (host_wr && (host_addr == A_STAT) && host_wdata[B_ERR]) begin
            err_q <= 1'b0;
        end
    end

    always_comb begin
        host_rdata = '0;
        unique case (host_addr)
            A_WWORD: host_rdata = wword_q;
            A_RWORD: host_rdata[DATA_W-1:0] = rd_result;
            A_STAT: begin
                host_rdata[B_BUSY] = busy;
                host_rdata[B_ERR]  = err_q;
            end
            A_TIME:  host_rdata[TIME_USED-1:0] = {t_hold, t_active, t_setup};
            default: host_rdata = '0;
        endcase
    end
endmodule

// File: rtl/lcdp_seq.sv
module lcdp_seq
    import lcdp_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  xfer_t                 start_xfer,
    input  logic [CNT_W-1:0]      t_setup,
    input  logic [CNT_W-1:0]      t_active,
    input  logic [CNT_W-1:0]      t_hold,
    input  logic [DATA_W-1:0]     pd_in,
    output logic                  busy,
    output logic [NUM_PANELS-1:0] cs_n,
    output logic                  rs,
    output logic                  wr_n,
    output logic                  rd_n,
    output logic [DATA_W-1:0]     pd_out,
    output logic                  pd_oe,
    output logic [DATA_W-1:0]     rd_result
);
    phase_t           state_q;
    phase_t           state_d;
    xfer_t            cur_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] act_q;
    logic [CNT_W-1:0] hold_q;
    logic             last;

    function automatic logic [CNT_W-1:0] width_m1(input logic [CNT_W-1:0] w);
        return (w == '0) ? '0 : w - CNT_W'(1);
    endfunction

    assign last = (cnt_q == '0);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_IDLE:   if (start) state_d = PH_SETUP;
            PH_SETUP:  if (last)  state_d = PH_STROBE;
            PH_STROBE: if (last)  state_d = PH_HOLD;
            PH_HOLD:   if (last)  state_d = PH_IDLE;
            default:              state_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= PH_IDLE;
            cur_q     <= '0;
            cnt_q     <= '0;
            act_q     <= '0;
            hold_q    <= '0;
            rd_result <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                PH_IDLE: if (start) begin
                    cur_q  <= start_xfer;
                    cnt_q  <= width_m1(t_setup);
                    act_q  <= width_m1(t_active);
                    hold_q <= width_m1(t_hold);
                end
                PH_SETUP: cnt_q <= last ? act_q : cnt_q - CNT_W'(1);
                PH_STROBE: begin
                    cnt_q <= last ? hold_q : cnt_q - CNT_W'(1);
                    if (last && cur_q.is_read) rd_result <= pd_in;
                end
                PH_HOLD: cnt_q <= last ? '0 : cnt_q - CNT_W'(1);
                default: cnt_q <= '0;
            endcase
        end
    end

    logic active;
    assign active = (state_q != PH_IDLE);

    genvar g;
    generate
        for (g = 0; g < NUM_PANELS; g++) begin : g_cs
            assign cs_n[g] = !(active && (int'(cur_q.panel) == g));
        end
    endgenerate

    always_comb begin
        busy   = active;
        rs     = active ? cur_q.rs : 1'b0;
        wr_n   = !((state_q == PH_STROBE) && !cur_q.is_read);
        rd_n   = !((state_q == PH_STROBE) && cur_q.is_read);
        pd_oe  = active && !cur_q.is_read;
        pd_out = pd_oe ? cur_q.data : '0;
    end
endmodule

// File: rtl/lcdp_host_port.sv
module lcdp_host_port
    import lcdp_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     host_addr,
    input  logic                  host_wr,
    input  logic [REG_W-1:0]      host_wdata,
    output logic [REG_W-1:0]      host_rdata,
    output logic [NUM_PANELS-1:0] pnl_cs_n,
    output logic                  pnl_rs,
    output logic                  pnl_wr_n,
    output logic                  pnl_rd_n,
    output logic [DATA_W-1:0]     pnl_d_out,
    output logic                  pnl_d_oe,
    input  logic [DATA_W-1:0]     pnl_d_in
);
    logic              busy;
    logic              start;
    xfer_t             start_xfer;
    logic [CNT_W-1:0]  t_setup;
    logic [CNT_W-1:0]  t_active;
    logic [CNT_W-1:0]  t_hold;
    logic [DATA_W-1:0] rd_result;
    logic              err_flag;
    logic              trig_any;

    lcdp_regs #(.CNT_W(CNT_W)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_addr  (host_addr),
        .host_wr    (host_wr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .busy       (busy),
        .rd_result  (rd_result),
        .start      (start),
        .start_xfer (start_xfer),
        .t_setup    (t_setup),
        .t_active   (t_active),
        .t_hold     (t_hold),
        .err_flag   (err_flag),
        .trig_any   (trig_any)
    );

    lcdp_seq #(.CNT_W(CNT_W)) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_xfer (start_xfer),
        .t_setup    (t_setup),
        .t_active   (t_active),
        .t_hold     (t_hold),
        .pd_in      (pnl_d_in),
        .busy       (busy),
        .cs_n       (pnl_cs_n),
        .rs         (pnl_rs),
        .wr_n       (pnl_wr_n),
        .rd_n       (pnl_rd_n),
        .pd_out     (pnl_d_out),
        .pd_oe      (pnl_d_oe),
        .rd_result  (rd_result)
    );
endmodule

// File: rtl/lcdp_host_port_chk.sv
module lcdp_host_port_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  pnl_cs_n,
    input logic        pnl_wr_n,
    input logic        pnl_rd_n,
    input logic        pnl_d_oe,
    input logic [15:0] pnl_d_out,
    input logic        busy,
    input logic        trig_any,
    input logic        err_flag
);
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(!pnl_wr_n && !pnl_rd_n)); // R10
    AST_STROBE_CS: assert property (@(posedge clk) disable iff (!rst_n) (!pnl_wr_n || !pnl_rd_n) |-> (pnl_cs_n != 2'b11)); // R10
    AST_ONE_CS: assert property (@(posedge clk) disable iff (!rst_n) $countones(~pnl_cs_n) <= 1); // R3
    AST_CS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (pnl_cs_n != 2'b11) == busy); // R4
    AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n) !pnl_rd_n |-> !pnl_d_oe); // R6
    AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (!pnl_wr_n && $past(!pnl_wr_n)) |-> $stable(pnl_d_out)); // R2
    AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n) (busy && trig_any) |=> err_flag); // R8
endmodule

bind lcdp_host_port lcdp_host_port_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pnl_cs_n  (pnl_cs_n),
    .pnl_wr_n  (pnl_wr_n),
    .pnl_rd_n  (pnl_rd_n),
    .pnl_d_oe  (pnl_d_oe),
    .pnl_d_out (pnl_d_out),
    .busy      (busy),
    .trig_any  (trig_any),
    .err_flag  (err_flag)
);

// File: tb/lcdp_host_port_tb.sv
`timescale 1ns/1ps
module lcdp_host_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  host_addr = 3'd0;
    logic        host_wr = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic [1:0]  pnl_cs_n;
    logic        pnl_rs, pnl_wr_n, pnl_rd_n, pnl_d_oe;
    logic [15:0] pnl_d_out;
    logic [15:0] pnl_d_in = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    lcdp_host_port dut_i (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .pnl_cs_n(pnl_cs_n),
        .pnl_rs(pnl_rs), .pnl_wr_n(pnl_wr_n), .pnl_rd_n(pnl_rd_n),
        .pnl_d_out(pnl_d_out), .pnl_d_oe(pnl_d_oe), .pnl_d_in(pnl_d_in)
    );

    task automatic chk(input string req, input bit ok, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic int eff(input int w);
        return (w == 0) ? 1 : w;
    endfunction

    function automatic logic [1:0] exp_cs(input bit panel);
        return panel ? 2'b01 : 2'b10;
    endfunction

    task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
        host_addr = a;
        #0.5;
        d = host_rdata;
    endtask

    int cur_s, cur_a, cur_h;

    task automatic set_time(input int s, input int a, input int h);
        cur_s = s; cur_a = a; cur_h = h;
        reg_wr(3'd5, {8'd0, h[7:0], a[7:0], s[7:0]});
    endtask

    // Runs one transfer and checks every phase; inject = trigger while busy
    task automatic do_xfer(input bit is_rd, input bit panel, input bit rsb,
                           input logic [15:0] val, input bit inject);
        int busy_n = 0, strb_n = 0, pre_n = 0, stat_n = 0;
        bit seen_strobe = 0, bad_rs = 0, bad_cs = 0, bad_oe = 0, bad_dat = 0;
        bit released = 0;
        logic [31:0] st;
        logic [15:0] rdv = val ^ 16'h5a5a;
        if (is_rd) reg_wr(3'd2, {7'd0, rsb, 24'd0});
        else       reg_wr(3'd0, {3'd0, 1'b1, 3'd0, rsb, 8'd0, val});
        pnl_d_in = rdv;
        @(negedge clk);
        host_addr = is_rd ? 3'd3 : 3'd1; host_wdata = {30'd0, panel, 1'b1}; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
        for (int k = 0; k < 2000; k++) begin
            reg_rd(3'd4, st);
            if (pnl_cs_n == 2'b11) break;
            busy_n++;
            if (st[1]) stat_n++;
            if (pnl_cs_n != exp_cs(panel)) bad_cs = 1;
            if (pnl_rs != rsb) bad_rs = 1;
            if (pnl_d_oe != !is_rd) bad_oe = 1;
            if (!is_rd && pnl_d_out != val) bad_dat = 1;
            if ((is_rd ? pnl_rd_n : pnl_wr_n) == 1'b0) begin
                strb_n++; seen_strobe = 1;
            end else if (!seen_strobe) pre_n++;
            else if (is_rd && !released) begin
                released = 1; pnl_d_in = ~rdv;
            end
            if ((is_rd ? pnl_wr_n : pnl_rd_n) == 1'b0) bad_oe = 1;
            if (inject && k == 0) begin
                host_addr = 3'd1; host_wdata = 32'h3; host_wr = 1'b1;
            end else begin
                host_wr = 1'b0;
            end
            @(negedge clk);
        end
        host_wr = 1'b0;
        chk("R4 busy length", busy_n == cur_s + cur_a + cur_h, busy_n, cur_s + cur_a + cur_h);
        chk("R4 status busy", stat_n == busy_n, stat_n, busy_n);
        chk("R5 setup width", pre_n == cur_s, pre_n, cur_s);
        chk("R5 strobe width", strb_n == cur_a, strb_n, cur_a);
        chk("R3 chip select", !bad_cs, bad_cs, 0);
        chk(is_rd ? "R6 rs" : "R2 rs", !bad_rs, bad_rs, 0);
        chk(is_rd ? "R6 oe" : "R2 oe", !bad_oe, bad_oe, 0);
        if (!is_rd) chk("R2 data", !bad_dat, bad_dat, 0);
        reg_rd(3'd4, st);
        chk("R4 idle after", st[1] == 1'b0, st[1], 0);
        if (is_rd) begin
            reg_rd(3'd2, st);
            chk("R7 read result", st == {16'd0, rdv}, st, {16'd0, rdv});
        end
        if (inject) begin
            reg_rd(3'd4, st);
            chk("R8 error set", st[2] == 1'b1, st[2], 1);
            reg_wr(3'd4, 32'h4);
            reg_rd(3'd4, st);
            chk("R8 error cleared", st[2] == 1'b0, st[2], 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd1234));
        cur_s = 1; cur_a = 2; cur_h = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 cs", pnl_cs_n == 2'b11, pnl_cs_n, 2'b11);
        chk("R1 strobes", {pnl_wr_n, pnl_rd_n} == 2'b11, {pnl_wr_n, pnl_rd_n}, 2'b11);
        chk("R1 oe", pnl_d_oe == 1'b0, pnl_d_oe, 0);
        reg_rd(3'd4, v);
        chk("R1 status", v == 0, v, 0);
        reg_rd(3'd5, v);
        chk("R1 timing", v == 32'h00010201, v, 32'h00010201);

        // directed: default widths, index then data write, main and secondary
        do_xfer(0, 0, 0, 16'h1234, 0);
        do_xfer(0, 1, 1, 16'hbeef, 0);
        do_xfer(1, 0, 1, 16'h0f0f, 0);
        // R5 zero widths count as one
        set_time(0, 0, 0);
        cur_s = 1; cur_a = 1; cur_h = 1;
        do_xfer(0, 0, 1, 16'hc3c3, 0);
        do_xfer(1, 1, 0, 16'h7e7e, 0);
        // wide transfer
        set_time(20, 30, 10);
        do_xfer(1, 0, 0, 16'ha5a5, 0);
        // R8 trigger while busy
        set_time(2, 3, 2);
        do_xfer(0, 0, 1, 16'h4242, 1);
        // R9 trigger with bit 0 clear
        reg_wr(3'd1, 32'h2);
        chk("R9 no start", pnl_cs_n == 2'b11, pnl_cs_n, 2'b11);
        reg_rd(3'd4, v);
        chk("R9 not busy", v[1] == 1'b0, v[1], 0);

        // random mix
        for (int i = 0; i < 40; i++) begin
            int s = $urandom_range(0, 5);
            int a = $urandom_range(0, 5);
            int h = $urandom_range(0, 5);
            reg_wr(3'd5, {8'd0, h[7:0], a[7:0], s[7:0]});
            cur_s = eff(s); cur_a = eff(a); cur_h = eff(h);
            do_xfer($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
                    16'($urandom), (i % 10) == 3);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule